// File: doc/BRIEF.md
# Phased Interval Waveform Scheduler

This block drives several periodic square waves from one shared free-running tick counter. Each wave can have its own phase and duty. The counter is never cleared. Each channel keeps a compare value. When the counter reaches that value, the channel inverts its wave and pulses an event. It then re-arms by adding the next interval to the compare value. The intervals used are the high length and the low length, in turn.

A single start strobe arms every channel at the same instant. It places each channel's first compare point a programmed lead-in delay after that instant, so the waves keep fixed phase offsets between them. A narrow write port loads the lead-in, high length and low length of each channel.

The write port is meant for a simple register path. Changes to the lengths are picked up at the channel's next compare event. A change to the lead-in is picked up at the next start.

Top module: `interval_sched`

## Requirements
- R1: `tick_o` is 0 in reset, rises by exactly one each clock after reset and wraps from 2^CNT_W-1 to 0. The start strobe never clears it.
- R2: After reset every `wave_o` and `evt_o` bit is 0, and it stays 0 until the first start strobe.
- R3: In the cycle after a start strobe is sampled, every wave is 0. Channel i's wave first goes to 1 exactly max(lead-in,1) clock edges after the start edge.
- R4: After the first rise, each wave stays high for max(high length,1) cycles and low for max(low length,1) cycles, and the two alternate for as long as the channel runs.
- R5: Compare arithmetic wraps modulo 2^CNT_W. An interval that crosses the counter wrap gives the same cycle count as one that does not, for any length up to 2^CNT_W-1.
- R6: `evt_o[i]` is 1 for exactly those cycles in which `wave_o[i]` shows a value newly produced by a compare event, and it is 0 in all other cycles.
- R7: A length or lead-in of 0 acts as 1.
- R8: A write takes effect in these ways:
  - A write sampled at an edge is used by the first compare event at a later edge (lengths) or by the first start at a later edge (lead-in).
  - Field code 0 is the lead-in, 1 is the high length and 2 is the low length.
  - A write with code 3, or to a channel index of N_CH or above, changes nothing.
- R9: A start strobe sampled while the channels are running re-arms all of them as in R3. A start beats a compare event on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe; arms all channels |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_chan | input | CH_W | Channel index of the write |
| wr_field | input | 2 | Field code: 0 lead-in, 1 high, 2 low, 3 none |
| wr_data | input | CNT_W | Value written |
| tick_o | output | CNT_W | Free-running shared counter |
| wave_o | output | N_CH | One wave per channel |
| evt_o | output | N_CH | One-cycle compare event per channel |

## Verification
The bench builds the block with three channels and an 8-bit counter.

With an 8-bit counter the wrap comes every 256 cycles, so many compare additions overflow during an ordinary run. The longest legal intervals, 255 cycles, can also be exercised within the cycle budget.

Three channels is not a power of two. This leaves channel index 3 addressable but nonexistent, so the out-of-range write path can be checked. The reference model counts down cycles instead of comparing modular values, which makes it an independent check on the wrap arithmetic.

// File: rtl/ivs_pkg.sv
// Shared definitions for the interval scheduler: field codes of the write port.
package ivs_pkg;
    typedef enum logic [1:0] {
        FLD_LEAD = 2'd0,
        FLD_HIGH = 2'd1,
        FLD_LOW  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;
endpackage

// File: rtl/ivs_tick_counter.sv
// Shared free-running counter. Assumes nothing ever clears it except reset;
// it wraps naturally at 2^CNT_W.
module ivs_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] tick
);
    // Advance by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + CNT_W'(1);
    end
endmodule

// File: rtl/ivs_cfg_bank.sv
// Per-channel configuration registers (lead-in, high length, low length).
// Assumes a write to a nonexistent channel or with the spare field code is
// simply dropped. Values are stored raw; zero is handled by the channels.
module ivs_cfg_bank
    import ivs_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CH_W-1:0]            wr_chan,
    input  logic [1:0]                 wr_field,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [N_CH-1:0][CNT_W-1:0] lead_o,
    output logic [N_CH-1:0][CNT_W-1:0] high_o,
    output logic [N_CH-1:0][CNT_W-1:0] low_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    fld_e fld;
    assign fld = fld_e'(wr_field);

    for (genvar c = 0; c < N_CH; c++) begin : g_reg
        logic [CNT_W-1:0] lead_r, high_r, low_r;
        logic             hit;

        assign hit = wr_en && (wr_chan == CH_W'(c));

        // Load the addressed field of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lead_r <= ONE;
                high_r <= ONE;
                low_r  <= ONE;
            end else if (hit) begin
                case (fld)
                    FLD_LEAD: lead_r <= wr_data;
                    FLD_HIGH: high_r <= wr_data;
                    FLD_LOW:  low_r  <= wr_data;
                    default:  ;
                endcase
            end
        end

        assign lead_o[c] = lead_r;
        assign high_o[c] = high_r;
        assign low_o[c]  = low_r;
    end
endmodule

// File: rtl/ivs_channel.sv
// One compare channel. On start it arms its compare point lead-in ticks ahead
// and drives its wave low. On each match it inverts the wave, flags an event
// and adds the next interval (high, then low, alternately) to the compare
// value, modulo 2^CNT_W. Assumes lengths are read at the match edge itself.
module ivs_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] tick,
    input  logic [CNT_W-1:0] lead_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] low_len,
    output logic             wave,
    output logic             evt
);
    // A zero length would mean a full revolution; treat it as one tick.
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    logic             running;
    logic             add_high;
    logic [CNT_W-1:0] cmp;
    logic             match;
    logic [CNT_W-1:0] step;

    assign match = running && (tick == cmp);
    assign step  = add_high ? at_least_one(high_len) : at_least_one(low_len);

    // Arm on start, re-arm and toggle on match; start wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            add_high <= 1'b1;
            cmp      <= '0;
            wave     <= 1'b0;
            evt      <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (start) begin
                running  <= 1'b1;
                add_high <= 1'b1;
                cmp      <= tick + at_least_one(lead_len);
                wave     <= 1'b0;
            end else if (match) begin
                wave     <= ~wave;
                evt      <= 1'b1;
                cmp      <= cmp + step;
                add_high <= ~add_high;
            end
        end
    end
endmodule

// File: rtl/interval_sched.sv
// Top of the phased interval scheduler: one shared counter, a configuration
// bank and N_CH compare channels. Assumes the start strobe is synchronous.
module interval_sched #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [1:0]       wr_field,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] tick_o,
    output logic [N_CH-1:0]  wave_o,
    output logic [N_CH-1:0]  evt_o
);
    logic [N_CH-1:0][CNT_W-1:0] lead_v, high_v, low_v;

    ivs_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_o)
    );

    ivs_cfg_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_chan  (wr_chan),
        .wr_field (wr_field),
        .wr_data  (wr_data),
        .lead_o   (lead_v),
        .high_o   (high_v),
        .low_o    (low_v)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ivs_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start),
            .tick     (tick_o),
            .lead_len (lead_v[c]),
            .high_len (high_v[c]),
            .low_len  (low_v[c]),
            .wave     (wave_o[c]),
            .evt      (evt_o[c])
        );
    end
endmodule

// File: rtl/interval_sched_chk.sv
// Port-level checker for interval_sched, attached by bind.
module interval_sched_chk #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] tick_o,
    input logic [N_CH-1:0]  wave_o,
    input logic [N_CH-1:0]  evt_o
);
    logic armed;

    // Remember whether any start has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (start) armed <= 1'b1;
    end

    // R1
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tick_o == $past(tick_o) + CNT_W'(1));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (wave_o == '0 && evt_o == '0));

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wave_o == '0 && evt_o == '0));

    for (genvar c = 0; c < N_CH; c++) begin : g_evt
        // R6
        evt_marks_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(start)) |-> (evt_o[c] == (wave_o[c] != $past(wave_o[c]))));
    end
endmodule

bind interval_sched interval_sched_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_sched_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tick_o (tick_o),
    .wave_o (wave_o),
    .evt_o  (evt_o)
);

// File: tb/interval_sched_bench.sv
module interval_sched_bench;
    localparam int N  = 3;
    localparam int W  = 8;
    localparam int CW = 2;
    localparam int MOD = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_chan = '0;
    logic [1:0]    wr_field = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  tick_o;
    logic [N-1:0]  wave_o, evt_o;

    int    total = 0;
    int    bad = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string cur_req = "R2";

    // Reference state, counted in cycles rather than compare values.
    int m_lead[N], m_high[N], m_low[N], m_rem[N];
    bit m_run[N], m_out[N], m_ph[N], m_ev[N];
    int m_tick;

    always #2 clk = ~clk;

    interval_sched #(.N_CH(N), .CNT_W(W)) u_interval_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_field(wr_field), .wr_data(wr_data),
        .tick_o(tick_o), .wave_o(wave_o), .evt_o(evt_o)
    );

    function automatic int cl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at each edge: events first, then writes (R8), start wins (R9).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0;
            for (int c = 0; c < N; c++) begin
                m_lead[c] = 1; m_high[c] = 1; m_low[c] = 1; m_rem[c] = 0;
                m_run[c] = 0; m_out[c] = 0; m_ph[c] = 1; m_ev[c] = 0;
            end
        end else begin
            m_tick = (m_tick + 1) % MOD;
            for (int c = 0; c < N; c++) begin
                m_ev[c] = 0;
                if (start) begin
                    m_run[c] = 1; m_out[c] = 0; m_ph[c] = 1;
                    m_rem[c] = cl1(m_lead[c]);
                end else if (m_run[c]) begin
                    m_rem[c]--;
                    if (m_rem[c] == 0) begin
                        m_out[c] = ~m_out[c];
                        m_ev[c] = 1;
                        m_rem[c] = m_ph[c] ? cl1(m_high[c]) : cl1(m_low[c]);
                        m_ph[c] = ~m_ph[c];
                    end
                end
            end
            if (wr_en && int'(wr_chan) < N) begin
                case (wr_field)
                    2'd0: m_lead[wr_chan] = int'(wr_data);
                    2'd1: m_high[wr_chan] = int'(wr_data);
                    2'd2: m_low[wr_chan]  = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // Compare ports against the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R1", int'(tick_o), m_tick);
            for (int c = 0; c < N; c++) begin
                chk(cur_req, int'(wave_o[c]), int'(m_out[c]));
                chk("R6", int'(evt_o[c]), int'(m_ev[c]));
            end
        end
    end

    task automatic step(input bit we, input int ch, input int fld, input int val, input bit st);
        @(negedge clk);
        wr_en = we; wr_chan = CW'(ch); wr_field = 2'(fld); wr_data = W'(val); start = st;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic cfg(input int ch, input int ld, input int hi, input int lo);
        step(1, ch, 0, ld, 0);
        step(1, ch, 1, hi, 0);
        step(1, ch, 2, lo, 0);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(posedge clk);
        chk_on = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: quiet before any start.
        cur_req = "R2";
        idle(20);

        // R3 and R7: staggered lead-ins, one channel all zeros.
        cur_req = "R3 R7";
        cfg(0, 3, 2, 5);
        cfg(1, 0, 0, 0);
        cfg(2, 10, 4, 1);
        step(0, 0, 0, 0, 1);
        idle(30);
        cur_req = "R4";
        idle(60);

        // R5: long intervals that cross the counter wrap.
        cur_req = "R5";
        cfg(0, 250, 200, 150);
        cfg(1, 255, 255, 255);
        cfg(2, 7, 131, 97);
        step(0, 0, 0, 0, 1);
        idle(1200);

        // R8: length changes mid-run, spare code and missing channel ignored.
        cur_req = "R8";
        cfg(0, 2, 3, 3);
        cfg(1, 1, 2, 2);
        cfg(2, 1, 1, 4);
        step(0, 0, 0, 0, 1);
        idle(15);
        step(1, 0, 1, 9, 0);
        idle(12);
        step(1, 1, 3, 0, 0);
        step(1, 3, 1, 0, 0);
        step(1, 3, 2, 0, 0);
        idle(20);
        step(1, 2, 2, 0, 0);
        idle(30);

        // R9: restart while running, repeatedly at odd points.
        cur_req = "R9";
        for (int k = 0; k < 8; k++) begin
            idle($urandom_range(1, 23));
            step(0, 0, 0, 0, 1);
        end
        idle(40);

        // Random configurations, writes and restarts.
        cur_req = "R4";
        for (int r = 0; r < 40; r++) begin
            for (int c = 0; c < N; c++) begin
                int big = ($urandom_range(0, 4) == 0);
                cfg(c, big ? $urandom_range(0, 255) : $urandom_range(0, 12),
                       big ? $urandom_range(0, 255) : $urandom_range(0, 12),
                       big ? $urandom_range(0, 255) : $urandom_range(0, 12));
            end
            step(0, 0, 0, 0, 1);
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(0, 19) == 0)
                    step(1, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15), 0);
                else if ($urandom_range(0, 299) == 0)
                    step(0, 0, 0, 0, 1);
                else
                    step(0, 0, 0, 0, 0);
            end
        end

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule